// File: doc/BRIEF.md
# Look-Aside Snarfing Cache

This block is a small direct-mapped cache placed beside main memory on a shared processor bus rather than in front of it. Every processor cycle is offered to memory and to the cache in the same clock. When the addressed line holds the requested word, the cache returns it and ends the cycle itself. It also tells memory to abandon that cycle. When the line does not hold the word, memory answers. The cache then copies the returned word and its tag into the indexed line at the clock edge that closes the cycle.

Each line holds one word, a tag and a valid bit. Processor writes always go to memory. A write that finds its line present also updates that line when memory accepts the write. A write to an absent line allocates nothing. While another bus master owns memory, processor cycles are held off. During that time the cache watches the other master's writes and refreshes any line whose address they hit, so it never keeps a stale copy.

The processor request is a valid/ready stream. The processor raises `cpu_req_valid` and keeps address, direction and write data stable until `cpu_req_ready` is seen high at a clock edge. `cpu_req_ready` is the cycle-terminate and may stay low for any number of cycles, for memory latency or for a foreign grant. The memory response and the snoop port carry no back-pressure: the cache accepts them in the cycle they are presented.

Top module: `snarf_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address is answered by memory (`mem_req_cancel` low in the terminating cycle).
- R2: In every cycle where `cpu_req_valid` is high and `alt_master_grant` is low, `mem_req_valid` is high in that same cycle, before any hit is known.
- R3: A read whose index (address bits [IDX_W-1:0]) selects a valid line with an equal tag (the remaining upper address bits) terminates in its first cycle with `cpu_req_ready` high, `mem_req_cancel` high and `cpu_rsp_data` equal to the line's word.
- R4: A read that misses terminates in the cycle `mem_rsp_valid` is high, returns `mem_rsp_data`, and stores that word and tag in the indexed line, so a repeat read of the address hits.
- R5: If `mem_rsp_valid` is high in a cycle where the read would hit, the cache does not terminate: `mem_req_cancel` stays low and the returned data is memory's.
- R6: While `alt_master_grant` is high, `cpu_req_ready` and `mem_req_valid` stay low, even for an address held in the cache.
- R7: A snooped write (`snoop_wr_valid`) whose address matches a valid line replaces that line's word. A snooped write to an absent address allocates nothing.
- R8: A processor write terminates when memory accepts it. If the line is present, it takes the new word at that edge. A write miss allocates nothing, so a following read of that address misses.
- R9: Two addresses with the same index and different tags share one line. A miss fill of one evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor cycle pending |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data (also seen by memory) |
| cpu_req_ready | output | 1 | Cycle terminate |
| cpu_rsp_data | output | DATA_W | Read data, valid with `cpu_req_ready` on reads |
| mem_req_valid | output | 1 | Processor cycle offered to memory |
| mem_req_cancel | output | 1 | Cache has answered, memory must drop the cycle |
| mem_rsp_valid | input | 1 | Memory terminates the cycle |
| mem_rsp_data | input | DATA_W | Memory read data |
| alt_master_grant | input | 1 | Another master owns memory |
| snoop_wr_valid | input | 1 | Other master writes this cycle |
| snoop_wr_addr | input | ADDR_W | Snooped write address |
| snoop_wr_data | input | DATA_W | Snooped write data |

## Verification
A read hit and memory's own terminate can land in the same cycle. The bench provokes this by setting the memory model's latency to zero for reads of cached addresses. In that case the cache must stay silent: no cancel, and the data comes from memory. It is judged by the cancel pin and the returned word in the terminating cycle. Snoop updates are also raised while a processor read waits on the foreign grant. A later read must hit and show the snooped word.

// File: rtl/snarf_pkg.sv
package snarf_pkg;
  // Which side ends the current processor cycle
  typedef enum logic [1:0] {
    TERM_NONE  = 2'd0,
    TERM_CACHE = 2'd1,
    TERM_MEM   = 2'd2
  } term_src_e;
endpackage

// File: rtl/snarf_tag_store.sv
module snarf_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic             valid_a,
  output logic [TAG_W-1:0] tag_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic             valid_b,
  output logic [TAG_W-1:0] tag_b,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]             valid_q;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[g] <= 1'b0;
          tag_q[g]   <= '0;
        end else if (fill_en && fill_idx == IDX_W'(g)) begin
          valid_q[g] <= 1'b1;
          tag_q[g]   <= fill_tag;
        end
      end
    end
  endgenerate

  assign valid_a = valid_q[rd_idx_a];
  assign tag_a   = tag_q[rd_idx_a];
  assign valid_b = valid_q[rd_idx_b];
  assign tag_b   = tag_q[rd_idx_b];

  // R1: the first sampled cycle after reset sees no valid line
  assert_inval_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));

  // R4: a fill leaves its line valid with the new tag
  assert_fill_sets_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/snarf_data_store.sv
module snarf_data_store #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pw_en,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic [DATA_W-1:0] pw_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [DATA_W-1:0] sw_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][DATA_W-1:0] word_q;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q[g] <= '0;
        end else if (pw_en && pw_idx == IDX_W'(g)) begin
          // processor-side update takes priority over a snoop
          word_q[g] <= pw_data;
        end else if (sw_en && sw_idx == IDX_W'(g)) begin
          word_q[g] <= sw_data;
        end
      end
    end
  endgenerate

  assign rd_data = word_q[rd_idx];

  // R7: a snoop update with no colliding processor write lands in the line
  assert_snoop_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !(pw_en && pw_idx == sw_idx)) |=> (word_q[$past(sw_idx)] == $past(sw_data)));
endmodule

// File: rtl/snarf_ctrl.sv
module snarf_ctrl
  import snarf_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic              line_valid,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              alt_master_grant,
  output logic              cpu_req_ready,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_cancel,
  output logic              fill_en,
  output logic              wr_upd_en
);
  logic      active;
  logic      hit;
  term_src_e term;

  always_comb begin
    active = cpu_req_valid && !alt_master_grant;
    hit    = line_valid && (line_tag == cpu_tag);
    term   = TERM_NONE;
    if (active) begin
      if (mem_rsp_valid)                 term = TERM_MEM;
      else if (!cpu_req_write && hit)    term = TERM_CACHE;
    end
  end

  assign mem_req_valid  = active;
  assign mem_req_cancel = (term == TERM_CACHE);
  assign cpu_req_ready  = (term != TERM_NONE);
  assign cpu_rsp_data   = (term == TERM_CACHE) ? line_data : mem_rsp_data;
  assign fill_en        = (term == TERM_MEM) && !cpu_req_write;
  assign wr_upd_en      = (term == TERM_MEM) && cpu_req_write && hit;

  // R3: memory is told to drop the cycle only when the cache ends it
  assert_cancel_ends_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_cancel |-> (cpu_req_ready && !cpu_req_write));

  // R5: cache and memory never both terminate
  assert_no_dual_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_cancel);

  // R6: a foreign grant blocks both the memory start and the terminate
  assert_grant_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alt_master_grant |-> (!cpu_req_ready && !mem_req_valid));

  // R2: no terminate without the cycle having been offered to memory
  assert_offer_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> mem_req_valid);
endmodule

// File: rtl/snarf_cache.sv
module snarf_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_cancel,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              alt_master_grant,
  input  logic              snoop_wr_valid,
  input  logic [ADDR_W-1:0] snoop_wr_addr,
  input  logic [DATA_W-1:0] snoop_wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  logic              line_valid, snp_valid;
  logic [TAG_W-1:0]  line_tag, snp_line_tag;
  logic [DATA_W-1:0] line_data;
  logic              fill_en, wr_upd_en, snp_hit;
  logic [DATA_W-1:0] pw_data;

  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_wr_addr[IDX_W-1:0];
  assign snp_tag = snoop_wr_addr[ADDR_W-1:IDX_W];

  snarf_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (cpu_idx),
    .valid_a  (line_valid),
    .tag_a    (line_tag),
    .rd_idx_b (snp_idx),
    .valid_b  (snp_valid),
    .tag_b    (snp_line_tag),
    .fill_en  (fill_en),
    .fill_idx (cpu_idx),
    .fill_tag (cpu_tag)
  );

  assign snp_hit = snoop_wr_valid && snp_valid && (snp_line_tag == snp_tag);
  assign pw_data = cpu_req_write ? cpu_req_wdata : mem_rsp_data;

  snarf_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (cpu_idx),
    .rd_data (line_data),
    .pw_en   (fill_en || wr_upd_en),
    .pw_idx  (cpu_idx),
    .pw_data (pw_data),
    .sw_en   (snp_hit),
    .sw_idx  (snp_idx),
    .sw_data (snoop_wr_data)
  );

  snarf_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .cpu_req_valid    (cpu_req_valid),
    .cpu_req_write    (cpu_req_write),
    .cpu_tag          (cpu_tag),
    .line_valid       (line_valid),
    .line_tag         (line_tag),
    .line_data        (line_data),
    .mem_rsp_valid    (mem_rsp_valid),
    .mem_rsp_data     (mem_rsp_data),
    .alt_master_grant (alt_master_grant),
    .cpu_req_ready    (cpu_req_ready),
    .cpu_rsp_data     (cpu_rsp_data),
    .mem_req_valid    (mem_req_valid),
    .mem_req_cancel   (mem_req_cancel),
    .fill_en          (fill_en),
    .wr_upd_en        (wr_upd_en)
  );

  // R4: a read ended by memory returns memory's word unchanged
  assert_miss_returns_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_ready && !mem_req_cancel && !cpu_req_write) |-> (cpu_rsp_data == mem_rsp_data));
endmodule

// File: tb/test_snarf_cache.sv
module test_snarf_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 3;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready;
  logic [DATA_W-1:0] cpu_rsp_data;
  logic mem_req_valid, mem_req_cancel, mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;
  logic alt_master_grant = 1'b0, snoop_wr_valid = 1'b0;
  logic [ADDR_W-1:0] snoop_wr_addr = '0;
  logic [DATA_W-1:0] snoop_wr_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snarf_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_snarf_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_cancel(mem_req_cancel),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .alt_master_grant(alt_master_grant), .snoop_wr_valid(snoop_wr_valid),
    .snoop_wr_addr(snoop_wr_addr), .snoop_wr_data(snoop_wr_data)
  );

  // memory model
  logic [DATA_W-1:0] mem_model [WORDS];
  int lat = 2;
  int wait_cnt = 0;
  assign mem_rsp_valid = mem_req_valid && (wait_cnt >= lat);
  assign mem_rsp_data  = mem_model[cpu_req_addr];

  always @(posedge clk) begin
    if (mem_rsp_valid && cpu_req_write) mem_model[cpu_req_addr] = cpu_req_wdata;
    if (mem_req_valid && !mem_req_cancel && !mem_rsp_valid) wait_cnt = wait_cnt + 1;
    else wait_cnt = 0;
  end

  // reference tag model
  logic             ref_valid [LINES];
  logic [ADDR_W-IDX_W-1:0] ref_tag [LINES];

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [ADDR_W-1:0] a);
    return ref_valid[a[IDX_W-1:0]] && ref_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
  endfunction

  // read: returns data, whether cache ended it, and waited cycles
  task automatic cpu_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                          output bit by_cache, output int cyc);
    @(negedge clk);
    cpu_req_addr = a; cpu_req_write = 1'b0; cpu_req_valid = 1'b1;
    cyc = 0; by_cache = 1'b0; d = '0;
    forever begin
      #1;
      if (cpu_req_ready) begin
        d = cpu_rsp_data; by_cache = mem_req_cancel;
        break;
      end
      if (cyc > 60) begin
        check(1'b0, "watchdog-read", cyc, 0);
        break;
      end
      @(negedge clk); cyc++;
    end
    @(posedge clk); #1 cpu_req_valid = 1'b0;
    ref_valid[a[IDX_W-1:0]] = 1'b1;
    ref_tag[a[IDX_W-1:0]]   = a[ADDR_W-1:IDX_W];
  endtask

  task automatic cpu_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int cyc;
    @(negedge clk);
    cpu_req_addr = a; cpu_req_write = 1'b1; cpu_req_wdata = d; cpu_req_valid = 1'b1;
    cyc = 0;
    forever begin
      #1;
      if (cpu_req_ready) break;
      if (cyc > 60) begin
        check(1'b0, "watchdog-write", cyc, 0);
        break;
      end
      @(negedge clk); cyc++;
    end
    @(posedge clk); #1 cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    alt_master_grant = 1'b1; snoop_wr_valid = 1'b1; snoop_wr_addr = a; snoop_wr_data = d;
    @(posedge clk); #1;
    mem_model[a] = d; snoop_wr_valid = 1'b0;
    @(negedge clk); alt_master_grant = 1'b0;
  endtask

  // read and compare against memory model and tag model
  task automatic read_chk(input logic [ADDR_W-1:0] a, input string req);
    logic [DATA_W-1:0] d, exp_d;
    bit bc, exp_bc;
    int cyc;
    exp_d  = mem_model[a];
    exp_bc = ref_hit(a) && (lat > 0);
    cpu_read(a, d, bc, cyc);
    check(d == exp_d, req, int'(d), int'(exp_d));
    check(bc == exp_bc, req, int'(bc), int'(exp_bc));
    if (exp_bc) check(cyc == 0, req, cyc, 0);
  endtask

  initial begin
    logic [DATA_W-1:0] d;
    bit bc;
    int cyc;
    bit ok_stall;
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) mem_model[i] = DATA_W'(i * 37 + 5);
    for (int i = 0; i < LINES; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(cpu_req_ready == 1'b0 && mem_req_valid == 1'b0, "R1", int'(cpu_req_ready), 0);

    // R1 / R4: first read misses with full latency, repeat hits (R3)
    lat = 3;
    cpu_read(8'h13, d, bc, cyc);
    check(bc == 1'b0, "R1", int'(bc), 0);
    check(cyc == 3, "R4", cyc, 3);
    check(d == mem_model[8'h13], "R4", int'(d), int'(mem_model[8'h13]));
    read_chk(8'h13, "R3");

    // R2: start seen in the first cycle of a miss
    @(negedge clk);
    cpu_req_addr = 8'h24; cpu_req_write = 1'b0; cpu_req_valid = 1'b1;
    #1 check(mem_req_valid == 1'b1 && mem_req_cancel == 1'b0, "R2", int'(mem_req_valid), 1);
    @(negedge clk); cpu_req_valid = 1'b0;
    @(negedge clk);

    // R5: memory answers in the same cycle as a hit
    lat = 0;
    cpu_read(8'h13, d, bc, cyc);
    check(bc == 1'b0, "R5", int'(bc), 0);
    check(d == mem_model[8'h13], "R5", int'(d), int'(mem_model[8'h13]));
    lat = 2;

    // R9: same index, other tag evicts
    read_chk(8'h1B, "R9");
    read_chk(8'h13, "R9");

    // R8: write hit updates line, write miss does not allocate
    cpu_write(8'h13, 16'hBEEF);
    read_chk(8'h13, "R8");
    cpu_write(8'h45, 16'h1111);
    read_chk(8'h45, "R8");

    // R6: stall under foreign grant, snoop (R7) while waiting
    @(negedge clk);
    alt_master_grant = 1'b1;
    cpu_req_addr = 8'h13; cpu_req_write = 1'b0; cpu_req_valid = 1'b1;
    ok_stall = 1'b1;
    for (int k = 0; k < 5; k++) begin
      if (k == 2) begin snoop_wr_valid = 1'b1; snoop_wr_addr = 8'h13; snoop_wr_data = 16'hC0DE; end
      #1 if (cpu_req_ready || mem_req_valid) ok_stall = 1'b0;
      @(posedge clk); #1;
      if (snoop_wr_valid) begin mem_model[8'h13] = 16'hC0DE; snoop_wr_valid = 1'b0; end
      @(negedge clk);
    end
    check(ok_stall, "R6", 0, 1);
    alt_master_grant = 1'b0;
    #1 check(cpu_req_ready && mem_req_cancel, "R6", int'(cpu_req_ready), 1);
    check(cpu_rsp_data == 16'hC0DE, "R7", int'(cpu_rsp_data), 16'hC0DE);
    @(posedge clk); #1 cpu_req_valid = 1'b0;

    // R7: snoop to an absent address allocates nothing
    snoop(8'h77, 16'h7777);
    read_chk(8'h77, "R7");
    snoop(8'h77, 16'h8888);
    read_chk(8'h77, "R7");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [ADDR_W-1:0] a;
      int op;
      a   = {3'b000, 5'($urandom_range(0, 31))};
      op  = $urandom_range(0, 9);
      lat = $urandom_range(0, 3);
      if (op < 6)      read_chk(a, "R3/R4 random");
      else if (op < 8) cpu_write(a, DATA_W'($urandom));
      else             snoop(a, DATA_W'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule